// File: doc/BRIEF.md
# Burst-Counted SPI Master

This block is a register-mapped SPI master built around two byte FIFOs and a burst sequencer. Software fills the transmit FIFO through a data register and writes two 24-bit counts: how many bytes the burst moves, and how many of those come from the transmit FIFO. It then sets the exchange bit in the control register. The sequencer shifts one byte in and one byte out per slot until the burst count is spent, and then clears the exchange bit by itself. Slots beyond the transmit count send 0x00. Every byte clocked in lands in the receive FIFO, and software pops it through a second data register.

The serial clock runs from an external one-cycle tick: each tick is one half period of SCK. The control register sets clock polarity and phase and picks one of four chip-select lines with a programmable active level. A line is either driven by the burst (automatic) or held by a software level bit (manual). Two self-clearing control bits empty the FIFOs, and a status register reports both fill levels.

Top module: `spi_burst_master`

## Requirements
- R1: Register offsets are 0x00 receive data, 0x04 transmit data, 0x08 control, 0x20 burst count, 0x24 transmit count and 0x28 FIFO status. Control holds enable in bit 0, master in bit 1, clock phase in bit 2, clock polarity in bit 3, active-low chip-select in bit 4, chip-select number in bits 13:12, manual chip-select in bit 16 and manual level in bit 17. After reset every register reads 0.
- R2: A write to transmit data pushes the low byte, and a read of receive data returns and pops the oldest byte. Each FIFO holds 64 bytes, and a push to a full FIFO is dropped. FIFO status gives the receive fill level in bits 6:0 and the transmit fill level in bits 22:16.
- R3: Writing control with bit 8 set empties the transmit FIFO, and writing it with bit 9 set empties the receive FIFO. Both bits read back as 0.
- R4: Writing 1 to control bit 10 while it is 0 latches both counts and starts a burst. Bit 10 reads 1 until the burst is finished and then clears by itself. Writing 0 to it during a burst has no effect.
- R5: A burst moves exactly burst-count bytes. The first transmit-count bytes are popped from the transmit FIFO, and the remaining slots send 0x00 without popping.
- R6: Each byte received in a burst is pushed into the receive FIFO in arrival order.
- R7: Bytes shift MSB first. SCK idles at the clock-polarity level. With phase 0 both sides sample on the leading edge; with phase 1 they sample on the trailing edge.
- R8: SCK changes level only on a cycle with the tick input high, and a byte takes 16 ticks.
- R9: A burst advances only while enable and master are both 1. Otherwise bit 10 stays set and nothing shifts.
- R10: With manual chip-select off, the selected line is at its active level while a burst is running, and every other line stays at the inactive level. Bit 4 = 1 makes the active level 0.
- R11: With manual chip-select on, the selected line follows bit 17 directly, and the other lines stay inactive.
- R12: A software push and an engine pop on the transmit FIFO in the same cycle both take effect. The same holds for an engine push and a software pop on the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_tick | input | 1 | One-cycle pulse per SCK half period |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on receive data) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select line levels |

## Verification
Both FIFOs can be touched from both sides in one cycle. The sequencer pops the transmit FIFO while software pushes to it, and the sequencer pushes a received byte while software pops the receive FIFO. The bench provokes both by writing extra transmit bytes and draining the receive FIFO while a burst is running, with a randomly paced SCK tick so the collisions land on varying cycles. It judges the outcome from the final transmit fill level, which must equal the extra bytes. It also checks that every received byte comes out in order, matched against the bytes a bus monitor captured on the serial lines.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned ADDR_W   = 6;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NUM_CS   = 4;
  localparam int unsigned CS_SEL_W = $clog2(NUM_CS);

  localparam logic [ADDR_W-1:0] OFF_RXD  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_TXD  = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CTL  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_BCNT = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_TCNT = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_FSTA = 6'h28;

  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_MASTER = 1;
  localparam int unsigned B_CPHA   = 2;
  localparam int unsigned B_CPOL   = 3;
  localparam int unsigned B_CSAL   = 4;
  localparam int unsigned B_TXRST  = 8;
  localparam int unsigned B_RXRST  = 9;
  localparam int unsigned B_XCH    = 10;
  localparam int unsigned B_CSSEL  = 12;
  localparam int unsigned B_CSMAN  = 16;
  localparam int unsigned B_CSLVL  = 17;
  localparam int unsigned B_TXLVL  = 16;

  typedef struct packed {
    logic                cs_lvl;
    logic                cs_man;
    logic [CS_SEL_W-1:0] cs_sel;
    logic                cs_al;
    logic                cpol;
    logic                cpha;
    logic                master;
    logic                en;
  } ctl_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           push,
  input  logic [W-1:0]   wdata,
  input  logic           pop,
  output logic [W-1:0]   rdata,
  output logic [$clog2(DEPTH):0] count,
  output logic           full,
  output logic           empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wp_n = wp_q + AW'(1);
      if (do_pop)  rp_n = rp_q + AW'(1);
      cnt_n = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign count = cnt_q;

  // R2: fill level never passes the depth
  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R3: a reset request leaves the FIFO empty
  p_flush_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  // R12: a push and a pop in one cycle keep the level
  p_both_sides_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty && !full && !flush) |=> $stable(count));
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_data
);
  localparam int EDGE_W = $clog2(2 * BYTE_W);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * BYTE_W - 1);

  logic              act_q, act_n, sck_q, sck_n, done_q, done_n;
  logic [EDGE_W-1:0] edge_q, edge_n;
  logic [BYTE_W-1:0] tx_q, tx_n, rx_q, rx_n;

  always_comb begin
    act_n  = act_q;
    edge_n = edge_q;
    tx_n   = tx_q;
    rx_n   = rx_q;
    sck_n  = sck_q;
    done_n = 1'b0;
    if (load) begin
      act_n  = 1'b1;
      edge_n = '0;
      tx_n   = load_data;
      sck_n  = cpol;
    end else if (act_q) begin
      if (tick) begin
        sck_n  = ~sck_q;
        edge_n = edge_q + EDGE_W'(1);
        if (edge_q[0] == cpha) rx_n = {rx_q[BYTE_W-2:0], miso};
        else if (edge_q != '0) tx_n = {tx_q[BYTE_W-2:0], 1'b0};
        if (edge_q == LAST_EDGE) begin
          act_n  = 1'b0;
          done_n = 1'b1;
        end
      end
    end else begin
      sck_n = cpol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_n;
      edge_q <= edge_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      sck_q  <= sck_n;
      done_q <= done_n;
    end
  end

  assign sck     = sck_q;
  assign mosi    = tx_q[BYTE_W-1];
  assign busy    = act_q;
  assign done    = done_q;
  assign rx_data = rx_q;

  // R8: no SCK movement without a tick while a byte is in flight
  p_sck_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sck));
  // R8: every tick in flight moves SCK
  p_sck_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick) |=> (sck != $past(sck)));
  // R5: the sequencer never reloads a byte in flight
  p_no_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs
);
  localparam int FC_W = $clog2(FIFO_DEPTH) + 1;

  logic [1:0] rst_pipe;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  ctl_t             ctl_q, ctl_n;
  logic             xch_q, xch_n;
  logic [CNT_W-1:0] bcnt_q, bcnt_n, tcnt_q, tcnt_n;
  logic [CNT_W-1:0] bleft_q, bleft_n, tleft_q, tleft_n;

  logic wr_ctl, wr_bcnt, wr_tcnt, tx_push, rx_pop, tx_flush, rx_flush;
  logic run, start, byte_go, finish, tx_take, auto_on;
  logic eng_busy, eng_done;
  logic [BYTE_W-1:0] eng_rx, tx_head, rx_head, load_data;
  logic [FC_W-1:0]   tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic unused_bits;

  assign wr_ctl   = reg_wr && (reg_addr == OFF_CTL);
  assign wr_bcnt  = reg_wr && (reg_addr == OFF_BCNT);
  assign wr_tcnt  = reg_wr && (reg_addr == OFF_TCNT);
  assign tx_push  = reg_wr && (reg_addr == OFF_TXD);
  assign rx_pop   = reg_rd && (reg_addr == OFF_RXD);
  assign tx_flush = wr_ctl && reg_wdata[B_TXRST];
  assign rx_flush = wr_ctl && reg_wdata[B_RXRST];

  assign run       = ctl_q.en && ctl_q.master;
  assign start     = wr_ctl && reg_wdata[B_XCH] && !xch_q;
  assign byte_go   = xch_q && run && !eng_busy && (bleft_q != '0);
  assign finish    = xch_q && run && !eng_busy && (bleft_q == '0);
  assign tx_take   = byte_go && (tleft_q != '0);
  assign load_data = (tx_take && !tx_empty) ? tx_head : '0;
  assign auto_on   = xch_q && run;

  always_comb begin
    ctl_n   = ctl_q;
    xch_n   = xch_q;
    bcnt_n  = bcnt_q;
    tcnt_n  = tcnt_q;
    bleft_n = bleft_q;
    tleft_n = tleft_q;
    if (wr_ctl) begin
      ctl_n.en     = reg_wdata[B_EN];
      ctl_n.master = reg_wdata[B_MASTER];
      ctl_n.cpha   = reg_wdata[B_CPHA];
      ctl_n.cpol   = reg_wdata[B_CPOL];
      ctl_n.cs_al  = reg_wdata[B_CSAL];
      ctl_n.cs_sel = reg_wdata[B_CSSEL +: CS_SEL_W];
      ctl_n.cs_man = reg_wdata[B_CSMAN];
      ctl_n.cs_lvl = reg_wdata[B_CSLVL];
    end
    if (wr_bcnt) bcnt_n = reg_wdata[CNT_W-1:0];
    if (wr_tcnt) tcnt_n = reg_wdata[CNT_W-1:0];
    if (start) begin
      xch_n   = 1'b1;
      bleft_n = bcnt_q;
      tleft_n = tcnt_q;
    end else if (byte_go) begin
      bleft_n = bleft_q - CNT_W'(1);
      if (tleft_q != '0) tleft_n = tleft_q - CNT_W'(1);
    end else if (finish) begin
      xch_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctl_q   <= '0;
      xch_q   <= 1'b0;
      bcnt_q  <= '0;
      tcnt_q  <= '0;
      bleft_q <= '0;
      tleft_q <= '0;
    end else begin
      ctl_q   <= ctl_n;
      xch_q   <= xch_n;
      bcnt_q  <= bcnt_n;
      tcnt_q  <= tcnt_n;
      bleft_q <= bleft_n;
      tleft_q <= tleft_n;
    end
  end

  spim_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n_i), .flush(tx_flush), .push(tx_push),
    .wdata(reg_wdata[BYTE_W-1:0]), .pop(tx_take), .rdata(tx_head),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n_i), .flush(rx_flush), .push(eng_done),
    .wdata(eng_rx), .pop(rx_pop), .rdata(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spim_shift u_eng (
    .clk(clk), .rst_n(rst_n_i), .tick(sck_tick), .cpol(ctl_q.cpol),
    .cpha(ctl_q.cpha), .load(byte_go), .load_data(load_data),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .busy(eng_busy),
    .done(eng_done), .rx_data(eng_rx));

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spi_cs[i] = (ctl_q.cs_sel != CS_SEL_W'(i)) ? ctl_q.cs_al :
                       ctl_q.cs_man ? ctl_q.cs_lvl :
                       (auto_on ? ~ctl_q.cs_al : ctl_q.cs_al);
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFF_RXD:  reg_rdata[BYTE_W-1:0] = rx_head;
      OFF_CTL: begin
        reg_rdata[B_EN]                  = ctl_q.en;
        reg_rdata[B_MASTER]              = ctl_q.master;
        reg_rdata[B_CPHA]                = ctl_q.cpha;
        reg_rdata[B_CPOL]                = ctl_q.cpol;
        reg_rdata[B_CSAL]                = ctl_q.cs_al;
        reg_rdata[B_XCH]                 = xch_q;
        reg_rdata[B_CSSEL +: CS_SEL_W]   = ctl_q.cs_sel;
        reg_rdata[B_CSMAN]               = ctl_q.cs_man;
        reg_rdata[B_CSLVL]               = ctl_q.cs_lvl;
      end
      OFF_BCNT: reg_rdata[CNT_W-1:0] = bcnt_q;
      OFF_TCNT: reg_rdata[CNT_W-1:0] = tcnt_q;
      OFF_FSTA: begin
        reg_rdata[FC_W-1:0]          = rx_cnt;
        reg_rdata[B_TXLVL +: FC_W]   = tx_cnt;
      end
      default:  reg_rdata = '0;
    endcase
  end

  assign unused_bits = ^{reg_wdata[DATA_W-1:CNT_W], tx_full, rx_full, rx_empty};

  // R4: the exchange bit only drops once the burst counter is spent
  p_xch_done_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(xch_q) |-> ($past(bleft_q) == '0));
  // R9: with the engine idle and not allowed to run, it stays idle
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!run && !eng_busy) |=> !eng_busy);
  // R10: at most one chip-select line sits at its active level
  p_cs_single_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(spi_cs ^ {NUM_CS{ctl_q.cs_al}}));
  // R6: a finished byte appears in the receive FIFO unless software pops
  p_rx_push_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (eng_done && !rx_pop && !rx_flush && !rx_full) |=> (rx_cnt == $past(rx_cnt) + FC_W'(1)));
endmodule

// File: tb/spi_burst_master_bench.sv
module spi_burst_master_bench;
  logic        clk = 1'b0;
  logic        rst_n, sck_tick, reg_wr, reg_rd;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        spi_sck, spi_mosi, spi_miso;
  logic [3:0]  spi_cs, cs_snap;

  always #10 clk = ~clk;
  assign spi_miso = ~spi_mosi;

  spi_burst_master u_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .sck_tick(sck_tick), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs(spi_cs));

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] tx_b [64];
  logic [7:0] rx_got [64];
  logic [7:0] mon_q [$];
  logic       mon_en = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0, mon_prev = 1'b0;
  logic [7:0] mon_cap = '0;
  int         mon_bits = 0;

  // serial monitor: captures MOSI on the sampling edge of the active mode
  always @(spi_sck or mon_en) begin
    if (!mon_en) begin
      mon_bits = 0;
      mon_q.delete();
    end else if ((spi_sck !== mon_prev) && (((spi_sck != mon_cpol) ? 1'b1 : 1'b0) ^ mon_cpha)) begin
      mon_cap = {mon_cap[6:0], spi_mosi};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_q.push_back(mon_cap);
        mon_bits = 0;
      end
    end
    mon_prev = spi_sck;
  end

  initial begin
    sck_tick = 1'b0;
    forever begin
      @(negedge clk);
      sck_tick = ($urandom % 3) == 0;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1;
    v = reg_rdata;
    cs_snap = spi_cs;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic [31:0] ctl_word(bit en, bit ms, bit cpha, bit cpol, bit al,
                                           int sel, bit man, bit lvl);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[1] = ms; w[2] = cpha; w[3] = cpol; w[4] = al;
    w[13:12] = sel[1:0]; w[16] = man; w[17] = lvl;
    return w;
  endfunction

  function automatic logic [7:0] exp_mosi(int i, int m);
    return (i < m) ? tx_b[i] : 8'h00;
  endfunction

  function automatic logic [3:0] exp_cs(bit al, int sel, bit active);
    logic [3:0] v;
    v = {4{al}};
    if (active) v[sel] = ~al;
    return v;
  endfunction

  task automatic burst(input int n, input int m, input int extra, input bit pop_during,
                       input logic [31:0] base, input bit al, input int sel);
    logic [31:0] v;
    int got, guard, xdone, bad_rx, bad_mon;
    bit busy, cs_done;
    for (int i = 0; i < m; i++) begin
      tx_b[i] = 8'($urandom);
      wr(6'h04, {24'h0, tx_b[i]});
    end
    rd(6'h28, v);
    chk(v[22:16] == 7'(m), "R2 tx level after preload", {25'h0, v[22:16]}, m);
    wr(6'h20, n);
    wr(6'h24, m);
    mon_en = 1'b1;
    wr(6'h08, base | 32'h400);
    busy = 1'b1; guard = 0; got = 0; xdone = 0; cs_done = 1'b0;
    while (busy && guard < 20000) begin
      rd(6'h08, v);
      busy = v[10];
      if (busy && !cs_done) begin
        chk(cs_snap == exp_cs(al, sel, 1'b1), "R10 auto select during burst", cs_snap, exp_cs(al, sel, 1'b1));
        cs_done = 1'b1;
      end
      if (xdone < extra) begin
        wr(6'h04, 32'h5A + xdone);
        xdone++;
      end else if (pop_during) begin
        rd(6'h28, v);
        if (v[6:0] != 0 && got < 64) begin
          rd(6'h00, v);
          rx_got[got] = v[7:0];
          got++;
        end
      end
      guard++;
    end
    chk(!busy, "R4 exchange bit self-clears", busy, 0);
    chk(spi_cs == {4{al}}, "R10 idle select after burst", spi_cs, {4{al}});
    rd(6'h28, v);
    chk(int'(v[6:0]) + got == n, "R6 received byte total", int'(v[6:0]) + got, n);
    chk(v[22:16] == 7'(extra), "R12 tx level with concurrent pushes", {25'h0, v[22:16]}, extra);
    for (int i = got; i < n && i < 64; i++) begin
      rd(6'h00, v);
      rx_got[i] = v[7:0];
    end
    bad_rx = 0;
    for (int i = 0; i < n; i++) if (rx_got[i] !== ~exp_mosi(i, m)) bad_rx++;
    chk(bad_rx == 0, "R6 R12 received byte order", bad_rx, 0);
    chk(mon_q.size() == n, "R5 bytes on the wire", mon_q.size(), n);
    bad_mon = 0;
    for (int i = 0; i < n && i < mon_q.size(); i++) if (mon_q[i] !== exp_mosi(i, m)) bad_mon++;
    chk(bad_mon == 0, "R5 R7 wire bytes MSB first with zero pad", bad_mon, 0);
    mon_en = 1'b0;
    wr(6'h08, base | 32'h100);
    rd(6'h28, v);
    chk(v[22:16] == 0, "R3 tx reset empties", {25'h0, v[22:16]}, 0);
  endtask

  initial begin
    logic [31:0] v, base;
    bit al, cpol, cpha;
    int n, m;
    void'($urandom(32'h0BAD_5EED));
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(6'h08, v); chk(v == 0, "R1 control after reset", v, 0);
    rd(6'h28, v); chk(v == 0, "R1 status after reset", v, 0);
    rd(6'h20, v); chk(v == 0, "R1 burst count after reset", v, 0);
    chk(spi_cs == 4'b0000 && spi_sck == 1'b0, "R1 pins after reset", {27'h0, spi_sck, spi_cs}, 0);
    wr(6'h20, 32'hFFFF_FFFF);
    rd(6'h20, v); chk(v == 32'h00FF_FFFF, "R1 24-bit burst count", v, 32'h00FF_FFFF);

    // R2: fill to the brim, one more push is dropped
    base = ctl_word(1, 1, 0, 0, 0, 0, 0, 0);
    wr(6'h08, base);
    for (int i = 0; i < 65; i++) wr(6'h04, i);
    rd(6'h28, v); chk(v[22:16] == 7'd64, "R2 full tx level", {25'h0, v[22:16]}, 64);
    wr(6'h08, base | 32'h100);
    rd(6'h28, v); chk(v[22:16] == 0, "R3 tx flush", {25'h0, v[22:16]}, 0);
    rd(6'h08, v); chk(v[9:8] == 2'b00, "R3 reset bits read 0", v[9:8], 0);

    // directed bursts in mode 0
    mon_cpol = 1'b0; mon_cpha = 1'b0;
    burst(63, 63, 1, 1'b1, base, 1'b0, 0);
    burst(5, 0, 0, 1'b0, base, 1'b0, 0);
    burst(1, 1, 0, 1'b0, base, 1'b0, 0);
    burst(0, 0, 0, 1'b0, base, 1'b0, 0);

    // all four clock modes with random bursts
    for (int md = 0; md < 4; md++) begin
      cpol = md[1]; cpha = md[0]; al = 1'($urandom);
      base = ctl_word(1, 1, cpha, cpol, al, md, 0, 0);
      wr(6'h08, base);
      mon_cpol = cpol; mon_cpha = cpha;
      repeat (3) @(negedge clk);
      chk(spi_sck == cpol, "R7 idle clock level", spi_sck, cpol);
      chk(spi_cs == {4{al}}, "R10 idle select lines", spi_cs, {4{al}});
      for (int k = 0; k < 3; k++) begin
        n = 1 + ($urandom % 63);
        m = $urandom % (n + 1);
        burst(n, m, $urandom % 4, k[0], base, al, md);
      end
    end

    // R9: stalled while disabled, then resumes
    base = ctl_word(1, 1, 0, 0, 1, 1, 0, 0);
    mon_cpol = 1'b0; mon_cpha = 1'b0;
    wr(6'h08, base & ~32'h1);
    tx_b[0] = 8'hC3; tx_b[1] = 8'h81;
    wr(6'h04, 32'hC3); wr(6'h04, 32'h81);
    wr(6'h20, 2); wr(6'h24, 2);
    mon_en = 1'b1;
    wr(6'h08, (base & ~32'h1) | 32'h400);
    repeat (100) @(negedge clk);
    rd(6'h08, v);
    chk(v[10] == 1'b1, "R9 R4 exchange bit held while disabled", v[10], 1);
    chk(cs_snap == 4'b1111, "R10 no select while stalled", cs_snap, 4'hF);
    rd(6'h28, v);
    chk(v[22:0] == 23'h020000, "R9 nothing moved while disabled", v, 32'h20000);
    chk(mon_q.size() == 0, "R9 no clock while disabled", mon_q.size(), 0);
    wr(6'h08, base);
    rd(6'h08, v);
    chk(v[10] == 1'b1, "R4 writing zero leaves exchange running", v[10], 1);
    for (int g = 0; g < 2000 && v[10]; g++) rd(6'h08, v);
    rd(6'h28, v);
    chk(v[6:0] == 7'd2, "R9 burst resumes after enable", v[6:0], 2);
    rd(6'h00, v); chk(v[7:0] == 8'h3C, "R6 first byte after resume", v[7:0], 8'h3C);
    rd(6'h00, v); chk(v[7:0] == 8'h7E, "R6 second byte after resume", v[7:0], 8'h7E);
    chk(mon_q.size() == 2 && mon_q[0] == 8'hC3, "R7 wire byte after resume", mon_q.size(), 2);
    mon_en = 1'b0;
    wr(6'h04, 32'h11);
    wr(6'h08, base | 32'h300);
    rd(6'h28, v); chk(v == 0, "R3 both FIFOs reset", v, 0);

    // R11: manual select
    wr(6'h08, ctl_word(1, 1, 0, 0, 1, 2, 1, 1));
    @(negedge clk); #1;
    chk(spi_cs == 4'b1111, "R11 manual level high", spi_cs, 4'b1111);
    wr(6'h08, ctl_word(1, 1, 0, 0, 1, 2, 1, 0));
    @(negedge clk); #1;
    chk(spi_cs == 4'b1011, "R11 manual level low", spi_cs, 4'b1011);
    wr(6'h08, ctl_word(1, 1, 0, 0, 0, 3, 1, 1));
    @(negedge clk); #1;
    chk(spi_cs == 4'b1000, "R11 manual level with active-high lines", spi_cs, 4'b1000);

    summary();
    $finish;
  end
endmodule